// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives a host processor byte- or word-wide access to a network adapter's local buffer memory through a single data port. The host first sets a 16-bit buffer address and a 16-bit transfer length, one byte at a time, through a small configuration write interface. After that, every strobe on the data port moves one unit between the host and the buffer. A unit is one byte, or one little-endian 16-bit word when the word-mode configuration bit is set. Each strobe then advances the address and reduces the remaining length.

The address runs through a receive ring whose first and last-plus-one pages are programmable. When an advanced address lands exactly on the ring's end page, it restarts at the ring's first page. Two regions of the buffer space are backed by storage: a small identification area at the bottom of the map and a packet-memory window. Reads outside both regions return all ones, and writes outside them are dropped.

A sticky completion flag tells the host that a transfer has finished. It is raised when the length runs out. It is also raised at once when the host issues a transfer command while the length is already zero. The flag stays set until the host clears it.

Top module: `rdma_port`

## Requirements
- R1: After reset the current address is 0, the remaining count is 0, the completion flag is 0, read-valid is 0, word mode is off, and the ring pages are the packet window's first page and its end page.
- R2: A configuration write loads one byte of a register, selected by code: 0 address low, 1 address high, 2 count low, 3 count high, 4 ring first page, 5 ring end page, 6 data configuration (bit 0 = word mode). The new value is visible on the next cycle.
- R3: In byte mode each strobe moves one byte at the current address and adds 1 to the address. Read data appears in bits 7:0 with bits 15:8 zero, and read-valid is high in the cycle after the read strobe.
- R4: In word mode the address is first forced even. Each strobe then moves two bytes, with the low data byte at the even address and the high data byte at the odd address, and the address advances by 2 from the even address.
- R5: If the advanced address equals the ring end page times 256, the address becomes the ring first page times 256.
- R6: If the remaining count is at most the access size, the count becomes 0 and the completion flag is set. Otherwise the access size is subtracted from the count.
- R7: A write strobe while the count is 0 changes neither memory, the address nor the count.
- R8: A read strobe while the count is 0 still returns data and advances the address, and it sets the completion flag.
- R9: A transfer command while the count is 0 sets the completion flag on the next cycle. With a nonzero count the command has no effect on the flag.
- R10: Only addresses below PROM_BYTES and inside [PMEM_START, PMEM_START+PMEM_BYTES) hold data. Reads elsewhere return 0x00FF in byte mode and 0xFFFF in word mode, and writes elsewhere are discarded. The address and count still advance.
- R11: The completion flag holds until a clear pulse. If a set condition and a clear pulse fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 3 | Configuration register select code |
| cfg_wdata | input | 8 | Configuration write byte |
| xfer_cmd | input | 1 | Transfer command pulse (remote read or write issued) |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 16 | Data port write data |
| port_rdata | output | 16 | Data port read data, registered |
| port_rvalid | output | 1 | Read data valid, one cycle after port_rd |
| done_clr | input | 1 | Clear pulse for the completion flag |
| dma_done | output | 1 | Sticky transfer completion flag |
| cur_addr | output | 16 | Current buffer address |
| cur_count | output | 16 | Remaining byte count |

## Verification
Two things can land on the completion flag in the same clock: a set, either from the access that drains the count or from a transfer command issued at zero count, and the host's clear pulse. The bench drives done_clr in the very cycle of the last read strobe, and again in the cycle of a zero-length command. In both cases it expects the flag to read high at the next sample, because the set must win. A clear pulse alone must bring the flag low, and it must stay low until a new set condition arrives.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 16;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;
   localparam int PAGE_W = 8;

   typedef enum logic [2:0] {
      SEL_ADDR_LO = 3'd0,
      SEL_ADDR_HI = 3'd1,
      SEL_CNT_LO  = 3'd2,
      SEL_CNT_HI  = 3'd3,
      SEL_RING_LO = 3'd4,
      SEL_RING_HI = 3'd5,
      SEL_DATACFG = 3'd6
   } cfg_sel_e;
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
   import rdma_pkg::*;
#(
   parameter int RST_FIRST_PG = 8'h40,
   parameter int RST_END_PG   = 8'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [BYTE_W-1:0] cfg_wdata,
   input  logic              step,
   input  logic              xfer_cmd,
   input  logic              done_clr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              word_mode,
   output logic              done_q
);
   logic [PAGE_W-1:0] first_pg, end_pg;
   logic [ADDR_W-1:0] size, nxt, wrapped;
   logic [CNT_W-1:0]  csize;
   logic              drains, set_done;
   cfg_sel_e          sel;

   assign sel      = cfg_sel_e'(cfg_sel);
   assign size     = word_mode ? ADDR_W'(2) : ADDR_W'(1);
   assign csize    = word_mode ? CNT_W'(2) : CNT_W'(1);
   assign eff_addr = word_mode ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
   assign nxt      = eff_addr + size;
   assign wrapped  = (nxt == {end_pg, {(ADDR_W-PAGE_W){1'b0}}}) ?
                     {first_pg, {(ADDR_W-PAGE_W){1'b0}}} : nxt;
   assign drains   = cnt_q <= csize;
   assign set_done = (step && drains) || (xfer_cmd && cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_pg  <= PAGE_W'(RST_FIRST_PG);
         end_pg    <= PAGE_W'(RST_END_PG);
         word_mode <= 1'b0;
      end else if (cfg_we) begin
         case (sel)
            SEL_RING_LO: first_pg  <= cfg_wdata;
            SEL_RING_HI: end_pg    <= cfg_wdata;
            SEL_DATACFG: word_mode <= cfg_wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (cfg_we && sel == SEL_ADDR_LO)
         addr_q <= {addr_q[ADDR_W-1:BYTE_W], cfg_wdata};
      else if (cfg_we && sel == SEL_ADDR_HI)
         addr_q <= {cfg_wdata, addr_q[BYTE_W-1:0]};
      else if (step)
         addr_q <= wrapped;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cfg_we && sel == SEL_CNT_LO)
         cnt_q <= {cnt_q[CNT_W-1:BYTE_W], cfg_wdata};
      else if (cfg_we && sel == SEL_CNT_HI)
         cnt_q <= {cfg_wdata, cnt_q[BYTE_W-1:0]};
      else if (step)
         cnt_q <= drains ? '0 : cnt_q - csize;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (set_done)
         done_q <= 1'b1;
      else if (done_clr)
         done_q <= 1'b0;
   end
endmodule

// File: rtl/rdma_window.sv
module rdma_window
   import rdma_pkg::*;
#(
   parameter int PROM_BYTES = 32,
   parameter int PMEM_START = 16'h4000,
   parameter int PMEM_BYTES = 1024,
   localparam int TOTAL = PROM_BYTES + PMEM_BYTES,
   localparam int IDX_W = $clog2(TOTAL)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W:0] PROM_END = (ADDR_W+1)'(PROM_BYTES);
   localparam logic [ADDR_W:0] PMEM_LO  = (ADDR_W+1)'(PMEM_START);
   localparam logic [ADDR_W:0] PMEM_HI  = (ADDR_W+1)'(PMEM_START + PMEM_BYTES);

   if (PROM_BYTES % 2 != 0 || PMEM_BYTES % 2 != 0 || PMEM_START % 2 != 0) begin : g_bad_align
      $error("rdma_window: regions must have even size and start");
   end
   if (PMEM_START < PROM_BYTES || PMEM_START + PMEM_BYTES > (1 << ADDR_W)) begin : g_bad_range
      $error("rdma_window: packet window overlaps or exceeds the address space");
   end

   logic [ADDR_W:0] a_ext;
   logic            in_prom, in_pmem;

   assign a_ext   = {1'b0, addr};
   assign in_prom = a_ext < PROM_END;
   assign in_pmem = (a_ext >= PMEM_LO) && (a_ext < PMEM_HI);
   assign hit     = in_prom || in_pmem;
   assign idx     = in_prom ? IDX_W'(a_ext) : IDX_W'(a_ext - PMEM_LO + PROM_END);
endmodule

// File: rtl/rdma_mem.sv
module rdma_mem
   import rdma_pkg::*;
#(
   parameter int DEPTH_BYTES = 1056,
   localparam int IDX_W = $clog2(DEPTH_BYTES),
   localparam int ROWS  = DEPTH_BYTES / 2
) (
   input  logic              clk,
   input  logic              we,
   input  logic              word,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rword,
   output logic [BYTE_W-1:0] rbyte
);
   logic [IDX_W-2:0]  row;
   logic [BYTE_W-1:0] lane_q [2];

   assign row = idx[IDX_W-1:1];

   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      logic [BYTE_W-1:0] bank [ROWS];
      logic              lane_we;
      logic [BYTE_W-1:0] lane_d;

      assign lane_we = we && (word || idx[0] == 1'(ln));
      assign lane_d  = word ? wdata[ln*BYTE_W +: BYTE_W] : wdata[BYTE_W-1:0];

      always_ff @(posedge clk) begin
         if (lane_we) bank[row] <= lane_d;
      end

      assign lane_q[ln] = bank[row];
   end

   assign rword = {lane_q[1], lane_q[0]};
   assign rbyte = idx[0] ? lane_q[1] : lane_q[0];
endmodule

// File: rtl/rdma_port.sv
module rdma_port
   import rdma_pkg::*;
#(
   parameter int PROM_BYTES = 32,
   parameter int PMEM_START = 16'h4000,
   parameter int PMEM_BYTES = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_sel,
   input  logic [7:0]  cfg_wdata,
   input  logic        xfer_cmd,
   input  logic        port_rd,
   input  logic        port_wr,
   input  logic [15:0] port_wdata,
   output logic [15:0] port_rdata,
   output logic        port_rvalid,
   input  logic        done_clr,
   output logic        dma_done,
   output logic [15:0] cur_addr,
   output logic [15:0] cur_count
);
   localparam int TOTAL  = PROM_BYTES + PMEM_BYTES;
   localparam int IDX_W  = $clog2(TOTAL);
   localparam int RST_FP = PMEM_START / 256;
   localparam int RST_EP = (PMEM_START + PMEM_BYTES) / 256;

   logic [ADDR_W-1:0] eff_addr;
   logic              word_mode, wr_take, step, hit;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] rword;
   logic [BYTE_W-1:0] rbyte;

   assign wr_take = port_wr && (cur_count != '0);
   assign step    = port_rd || wr_take;

   rdma_ptr #(.RST_FIRST_PG(RST_FP), .RST_END_PG(RST_EP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .step(step), .xfer_cmd(xfer_cmd),
      .done_clr(done_clr), .eff_addr(eff_addr), .addr_q(cur_addr),
      .cnt_q(cur_count), .word_mode(word_mode), .done_q(dma_done)
   );

   rdma_window #(.PROM_BYTES(PROM_BYTES), .PMEM_START(PMEM_START),
                 .PMEM_BYTES(PMEM_BYTES)) u_win (
      .addr(eff_addr), .hit(hit), .idx(idx)
   );

   rdma_mem #(.DEPTH_BYTES(TOTAL)) u_mem (
      .clk(clk), .we(wr_take && hit), .word(word_mode), .idx(idx),
      .wdata(port_wdata), .rword(rword), .rbyte(rbyte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_rdata  <= '0;
         port_rvalid <= 1'b0;
      end else begin
         port_rvalid <= port_rd;
         if (port_rd) begin
            if (word_mode)
               port_rdata <= hit ? rword : '1;
            else
               port_rdata <= {{BYTE_W{1'b0}}, hit ? rbyte : {BYTE_W{1'b1}}};
         end
      end
   end
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic        xfer_cmd,
   input logic        port_rd,
   input logic        port_wr,
   input logic        done_clr,
   input logic        word_mode,
   input logic        dma_done,
   input logic        port_rvalid,
   input logic [15:0] cur_addr,
   input logic [15:0] cur_count
);
   logic [15:0] sz;
   assign sz = word_mode ? 16'd2 : 16'd1;

   // R6
   drain_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && port_rd && cur_count <= sz) |=> dma_done);

   // R6
   count_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && port_rd && cur_count > sz) |=> (cur_count == $past(cur_count) - $past(sz)));

   // R7
   zero_count_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && port_wr && !port_rd && cur_count == 16'd0) |=> ($stable(cur_addr) && cur_count == 16'd0));

   // R9
   zero_len_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && xfer_cmd && cur_count == 16'd0) |=> dma_done);

   // R11
   clear_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr && !xfer_cmd && !port_rd && !port_wr) |=> !dma_done);

   // R11
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && !done_clr) |=> dma_done);

   // R3
   rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_rd |=> port_rvalid);

   // R3
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_rd |=> !port_rvalid);
endmodule

bind rdma_port rdma_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .xfer_cmd(xfer_cmd),
   .port_rd(port_rd), .port_wr(port_wr), .done_clr(done_clr),
   .word_mode(word_mode), .dma_done(dma_done), .port_rvalid(port_rvalid),
   .cur_addr(cur_addr), .cur_count(cur_count)
);

// File: tb/sim_rdma_port.sv
module sim_rdma_port;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        xfer_cmd = 1'b0;
   logic        port_rd = 1'b0;
   logic        port_wr = 1'b0;
   logic [15:0] port_wdata = '0;
   logic [15:0] port_rdata;
   logic        port_rvalid;
   logic        done_clr = 1'b0;
   logic        dma_done;
   logic [15:0] cur_addr, cur_count;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdma_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .xfer_cmd(xfer_cmd), .port_rd(port_rd),
      .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
      .port_rvalid(port_rvalid), .done_clr(done_clr), .dma_done(dma_done),
      .cur_addr(cur_addr), .cur_count(cur_count)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [7:0] val);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      cfg(3'd0, a[7:0]); cfg(3'd1, a[15:8]);
   endtask

   task automatic set_cnt(input logic [15:0] c);
      cfg(3'd2, c[7:0]); cfg(3'd3, c[15:8]);
   endtask

   task automatic set_word(input logic w);
      cfg(3'd6, {7'd0, w});
   endtask

   task automatic wr(input logic [15:0] d);
      port_wr = 1'b1; port_wdata = d;
      @(negedge clk);
      port_wr = 1'b0;
   endtask

   task automatic rd(output logic [15:0] d);
      port_rd = 1'b1;
      @(negedge clk);
      port_rd = 1'b0;
      d = port_rdata;
      check("R3 rvalid after read", {15'd0, port_rvalid}, 16'd1);
   endtask

   task automatic clear_done();
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 addr", cur_addr, 16'h0000);
      check("R1 count", cur_count, 16'h0000);
      check("R1 done", {15'd0, dma_done}, 16'd0);
      check("R1 rvalid", {15'd0, port_rvalid}, 16'd0);
   endtask

   task automatic t_regs();
      set_addr(16'h4010);
      set_cnt(16'h0003);
      check("R2 addr load", cur_addr, 16'h4010);
      check("R2 count load", cur_count, 16'h0003);
   endtask

   task automatic t_byte_write();
      wr(16'h00A1); check("R3 addr +1", cur_addr, 16'h4011);
      check("R6 count -1", cur_count, 16'h0002);
      wr(16'h00A2); wr(16'h00A3);
      check("R6 count drained", cur_count, 16'h0000);
      check("R6 done set", {15'd0, dma_done}, 16'd1);
      clear_done();
      check("R11 clear", {15'd0, dma_done}, 16'd0);
   endtask

   task automatic t_zero_write();
      set_addr(16'h4011);
      wr(16'h0055);
      check("R7 addr unchanged", cur_addr, 16'h4011);
      check("R7 count unchanged", cur_count, 16'h0000);
   endtask

   task automatic t_byte_read();
      logic [15:0] d;
      set_addr(16'h4010); set_cnt(16'h0003);
      rd(d); check("R3 byte 0", d, 16'h00A1);
      rd(d); check("R7 byte 1 kept", d, 16'h00A2);
      rd(d); check("R3 byte 2", d, 16'h00A3);
      check("R3 addr after reads", cur_addr, 16'h4013);
      clear_done();
   endtask

   task automatic t_word();
      logic [15:0] d;
      set_word(1'b1);
      set_addr(16'h4021); set_cnt(16'h0004);
      wr(16'hBEEF);
      check("R4 forced even +2", cur_addr, 16'h4022);
      wr(16'h1234);
      check("R4 addr", cur_addr, 16'h4024);
      check("R6 word drained", {15'd0, dma_done}, 16'd1);
      clear_done();
      set_word(1'b0);
      set_addr(16'h4020); set_cnt(16'h0002);
      rd(d); check("R4 low byte at even", d, 16'h00EF);
      rd(d); check("R4 high byte at odd", d, 16'h00BE);
      set_word(1'b1);
      set_addr(16'h4022); set_cnt(16'h0002);
      rd(d); check("R4 word read", d, 16'h1234);
      clear_done();
   endtask

   task automatic t_wrap();
      logic [15:0] d;
      set_addr(16'h43FE); set_cnt(16'h0004);
      wr(16'hAAAA);
      check("R5 wrap to first page", cur_addr, 16'h4000);
      wr(16'hBBBB);
      set_addr(16'h4000); set_cnt(16'h0002);
      rd(d); check("R5 data after wrap", d, 16'hBBBB);
      set_word(1'b0);
      cfg(3'd4, 8'h41); cfg(3'd5, 8'h42);
      set_addr(16'h41FF); set_cnt(16'h0002);
      wr(16'h0077);
      check("R5 byte wrap custom ring", cur_addr, 16'h4100);
      cfg(3'd4, 8'h40); cfg(3'd5, 8'h44);
      clear_done();
   endtask

   task automatic t_count();
      set_word(1'b1);
      set_addr(16'h4030); set_cnt(16'h0005);
      wr(16'h0101); check("R6 5-2", cur_count, 16'h0003);
      check("R6 not done", {15'd0, dma_done}, 16'd0);
      wr(16'h0202); check("R6 3-2", cur_count, 16'h0001);
      wr(16'h0303); check("R6 1 -> 0", cur_count, 16'h0000);
      check("R6 done on short tail", {15'd0, dma_done}, 16'd1);
      clear_done();
      set_word(1'b0);
   endtask

   task automatic t_cmd();
      set_cnt(16'h0000);
      xfer_cmd = 1'b1; @(negedge clk); xfer_cmd = 1'b0;
      check("R9 zero-length command", {15'd0, dma_done}, 16'd1);
      clear_done();
      set_cnt(16'h0002);
      xfer_cmd = 1'b1; @(negedge clk); xfer_cmd = 1'b0;
      check("R9 nonzero count no flag", {15'd0, dma_done}, 16'd0);
   endtask

   task automatic t_window();
      logic [15:0] d;
      set_addr(16'h0100); set_cnt(16'h0004);
      rd(d); check("R10 gap read byte", d, 16'h00FF);
      check("R10 addr advances", cur_addr, 16'h0101);
      wr(16'h0012);
      check("R10 discarded write advances", cur_addr, 16'h0102);
      set_addr(16'h4400);
      rd(d); check("R10 just past window", d, 16'h00FF);
      set_word(1'b1);
      set_addr(16'h2000);
      rd(d); check("R10 gap read word", d, 16'hFFFF);
      set_word(1'b0);
      set_addr(16'h0004); set_cnt(16'h0002);
      wr(16'h005A);
      set_addr(16'h0004);
      rd(d); check("R10 id area read back", d, 16'h005A);
      clear_done();
   endtask

   task automatic t_collide();
      set_addr(16'h4010); set_cnt(16'h0001);
      port_rd = 1'b1; done_clr = 1'b1;
      @(negedge clk);
      port_rd = 1'b0; done_clr = 1'b0;
      check("R11 drain beats clear", {15'd0, dma_done}, 16'd1);
      clear_done();
      xfer_cmd = 1'b1; done_clr = 1'b1;
      @(negedge clk);
      xfer_cmd = 1'b0; done_clr = 1'b0;
      check("R11 command beats clear", {15'd0, dma_done}, 16'd1);
      clear_done();
   endtask

   task automatic t_zero_read();
      logic [15:0] d;
      set_addr(16'h4010); set_cnt(16'h0000);
      rd(d); check("R8 read at zero count", d, 16'h00A1);
      check("R8 addr advances", cur_addr, 16'h4011);
      check("R8 done set", {15'd0, dma_done}, 16'd1);
      check("R8 count stays 0", cur_count, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_byte_write();
      t_zero_write();
      t_byte_read();
      t_word();
      t_wrap();
      t_count();
      t_cmd();
      t_window();
      t_collide();
      t_zero_read();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule